// File: doc/BRIEF.md
# Masked BSSID receive address filter

This block decides, for each received frame header, whether the frame is addressed to this station and should be acknowledged and delivered. It holds a 48-bit station address, a 48-bit joined BSSID with its 14-bit association ID, a 48-bit comparison mask and a 64-bit multicast hash table. Software loads these through a 32-bit word-write port. It can also set or clear a single hash-table bit by index through a separate operation port.

Frame BSSIDs are compared against the station address only on the bits the mask selects. Several virtual BSSes that share those bits with the station address therefore all pass. The planned cost is that unrelated BSSIDs which happen to agree on the masked bits pass as well.

The destination check has three cases. A broadcast destination passes. A group destination passes when its precomputed hash index selects a set table bit. A unicast destination passes when it masked-matches the station address. The decision appears one clock after the header is presented.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset the station address, joined BSSID, association ID and hash table are all zero, the mask is all ones, and `acc_valid`, `acc_ok` and `mc_err` are low.
- R2: The BSSID test passes when ((frame BSSID XOR station address) AND mask) is zero, or when the frame BSSID equals the joined BSSID exactly; a mask built as the AND of NOT(station XOR BSS) over several BSSes lets every one of them pass.
- R3: With the mask all ones, a frame BSSID that differs from both the station address and the joined BSSID in any single bit fails.
- R4: With station address 0x1 and mask 0x2 (all other mask bits zero), frame BSSIDs 0x4, 0x9 and 0xD pass and 0x6 fails.
- R5: Each 48-bit address is written as two words. Select 0/1 loads the station address low 32 bits and high 16 bits. Select 2/3 does the same for the joined BSSID, and select 4/5 for the mask. In each high word the address bits sit in `reg_wdata[15:0]`.
- R6: A write to select 3 loads the association ID from `reg_wdata[29:16]`, 14 bits; `reg_wdata[31:30]` are ignored.
- R7: Select 6 loads hash bits 31:0 and select 7 loads hash bits 63:32, so hash index 32+j is bit j of the high word. An operation with `mc_op_set`=1 sets bit `mc_op_idx`, and with 0 clears it. If a word write and a bit operation land in the same cycle, the bit operation wins on its own bit.
- R8: A bit operation whose index is 64 or more raises `mc_err` for one cycle and leaves the table unchanged; a valid index leaves `mc_err` low.
- R9: A destination with bit 0 set (group bit) that is not all ones passes only when table bit `frm_hash` is set.
- R10: An all-ones destination always passes the destination test, whatever the table holds.
- R11: A destination with bit 0 clear passes only when ((destination XOR station address) AND mask) is zero.
- R12: `acc_valid` and `acc_ok` are registered. They reflect the frame presented in the previous cycle, evaluated against register contents before any write made in that same cycle. `acc_ok` is set only when both the BSSID and the destination tests pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Word write strobe |
| reg_sel | input | 3 | Word select (see R5, R7) |
| reg_wdata | input | 32 | Word write data |
| mc_op_valid | input | 1 | Hash table bit operation strobe |
| mc_op_set | input | 1 | 1 sets, 0 clears the indexed bit |
| mc_op_idx | input | 7 | Bit index of the operation |
| frm_valid | input | 1 | Frame header present |
| frm_bssid | input | 48 | Frame BSSID |
| frm_da | input | 48 | Frame destination address, bit 0 is the group bit |
| frm_hash | input | 6 | Precomputed multicast hash index |
| acc_valid | output | 1 | Decision valid |
| acc_ok | output | 1 | Frame accepted |
| mc_err | output | 1 | Refused bit operation |
| bss_id | output | 48 | Joined BSSID contents |
| assoc_id | output | 14 | Association ID contents |

## Verification
The bench sweeps every single-bit BSSID flip under a full mask. A design that compared whole words or ignored the high word would pass frames that differ only in bits 47:32. It walks all 64 hash indices and cross-checks the high-word mapping, which catches an off-by-32 or reversed index. It fires out-of-range operations and then probes the table to prove they changed nothing. A frame presented in the same cycle as a station-address write confirms that the old address is used. A design that bypassed the write would reject that frame.

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int ADDR_W  = 48,
  parameter int WORD_W  = 32,
  parameter int AID_W   = 14,
  parameter int MC_BITS = 64,
  parameter int SEL_W   = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic [SEL_W-1:0]            reg_sel,
  input  logic [WORD_W-1:0]           reg_wdata,
  input  logic                        mc_op_valid,
  input  logic                        mc_op_set,
  input  logic [$clog2(MC_BITS):0]    mc_op_idx,
  input  logic                        frm_valid,
  input  logic [ADDR_W-1:0]           frm_bssid,
  input  logic [ADDR_W-1:0]           frm_da,
  input  logic [$clog2(MC_BITS)-1:0]  frm_hash,
  output logic                        acc_valid,
  output logic                        acc_ok,
  output logic                        mc_err,
  output logic [ADDR_W-1:0]           bss_id,
  output logic [AID_W-1:0]            assoc_id
);
  localparam int HI_W     = ADDR_W - WORD_W;
  localparam int AID_LSB  = HI_W;
  localparam int IDX_W    = $clog2(MC_BITS);
  localparam int MC_WORDS = MC_BITS / WORD_W;
  localparam logic [SEL_W-1:0] SEL_STA_LO = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_STA_HI = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_BSS_LO = SEL_W'(2);
  localparam logic [SEL_W-1:0] SEL_BSS_HI = SEL_W'(3);
  localparam logic [SEL_W-1:0] SEL_MSK_LO = SEL_W'(4);
  localparam logic [SEL_W-1:0] SEL_MSK_HI = SEL_W'(5);
  localparam int SEL_MC0 = 6;

  logic [ADDR_W-1:0]  sta_q, bss_q, mask_q;
  logic [AID_W-1:0]   aid_q;
  logic [MC_BITS-1:0] mc_q, mc_d;
  logic               idx_ok;
  logic               wdata_unused;

  assign wdata_unused = ^reg_wdata[WORD_W-1:AID_LSB+AID_W];
  assign idx_ok = mc_op_idx < (IDX_W+1)'(MC_BITS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sta_q  <= '0;
      bss_q  <= '0;
      aid_q  <= '0;
      mask_q <= '1;
    end else if (reg_wr) begin
      case (reg_sel)
        SEL_STA_LO: sta_q[WORD_W-1:0]       <= reg_wdata;
        SEL_STA_HI: sta_q[ADDR_W-1:WORD_W]  <= reg_wdata[HI_W-1:0];
        SEL_BSS_LO: bss_q[WORD_W-1:0]       <= reg_wdata;
        SEL_BSS_HI: begin
          bss_q[ADDR_W-1:WORD_W] <= reg_wdata[HI_W-1:0];
          aid_q                  <= reg_wdata[AID_LSB +: AID_W];
        end
        SEL_MSK_LO: mask_q[WORD_W-1:0]      <= reg_wdata;
        SEL_MSK_HI: mask_q[ADDR_W-1:WORD_W] <= reg_wdata[HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    mc_d = mc_q;
    for (int k = 0; k < MC_WORDS; k++)
      if (reg_wr && reg_sel == SEL_W'(SEL_MC0 + k))
        mc_d[k*WORD_W +: WORD_W] = reg_wdata;
    if (mc_op_valid && idx_ok)
      mc_d[mc_op_idx[IDX_W-1:0]] = mc_op_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mc_q   <= '0;
      mc_err <= 1'b0;
    end else begin
      mc_q   <= mc_d;
      mc_err <= mc_op_valid && !idx_ok;
    end
  end

  logic bss_hit, da_bcast, da_self, dest_ok;

  assign bss_hit  = (((frm_bssid ^ sta_q) & mask_q) == '0) || (frm_bssid == bss_q);
  assign da_bcast = &frm_da;
  assign da_self  = ((frm_da ^ sta_q) & mask_q) == '0;
  assign dest_ok  = da_bcast || (frm_da[0] ? mc_q[frm_hash] : da_self);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_ok    <= 1'b0;
    end else begin
      acc_valid <= frm_valid;
      acc_ok    <= frm_valid && bss_hit && dest_ok;
    end
  end

  assign bss_id   = bss_q;
  assign assoc_id = aid_q;
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk #(
  parameter int ADDR_W  = 48,
  parameter int MC_BITS = 64
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     frm_valid,
  input logic [ADDR_W-1:0]        frm_bssid,
  input logic [ADDR_W-1:0]        frm_da,
  input logic                     mc_op_valid,
  input logic [$clog2(MC_BITS):0] mc_op_idx,
  input logic                     acc_valid,
  input logic                     acc_ok,
  input logic                     mc_err,
  input logic [ADDR_W-1:0]        mask,
  input logic [ADDR_W-1:0]        sta,
  input logic [ADDR_W-1:0]        bss_id
);
  localparam int IW = $clog2(MC_BITS) + 1;

  // R12
  acc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> acc_valid);

  // R12
  acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> (!acc_valid && !acc_ok));

  // R8
  bad_idx_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_op_valid && mc_op_idx >= IW'(MC_BITS)) |=> mc_err);

  // R8
  quiet_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mc_op_valid && mc_op_idx >= IW'(MC_BITS)) |=> !mc_err);

  // R3
  exact_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && (&mask) && frm_bssid != sta && frm_bssid != bss_id) |=> !acc_ok);

  // R10
  bcast_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && (&frm_da) && frm_bssid == bss_id) |=> acc_ok);
endmodule

bind rx_addr_filter rx_addr_filter_chk #(.ADDR_W(ADDR_W), .MC_BITS(MC_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_bssid(frm_bssid),
  .frm_da(frm_da), .mc_op_valid(mc_op_valid), .mc_op_idx(mc_op_idx),
  .acc_valid(acc_valid), .acc_ok(acc_ok), .mc_err(mc_err),
  .mask(mask_q), .sta(sta_q), .bss_id(bss_id)
);

// File: tb/test_rx_addr_filter.sv
module test_rx_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        mc_op_valid = 1'b0;
  logic        mc_op_set = 1'b0;
  logic [6:0]  mc_op_idx = '0;
  logic        frm_valid = 1'b0;
  logic [47:0] frm_bssid = '0;
  logic [47:0] frm_da = '0;
  logic [5:0]  frm_hash = '0;
  logic        acc_valid, acc_ok, mc_err;
  logic [47:0] bss_id;
  logic [13:0] assoc_id;

  int n_run = 0;
  int n_fail = 0;

  logic [47:0] m_sta = '0, m_bss = '0, m_mask = '1;
  logic [63:0] m_mc = '0;

  always #10 clk = ~clk;

  rx_addr_filter i_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .mc_op_valid(mc_op_valid), .mc_op_set(mc_op_set), .mc_op_idx(mc_op_idx),
    .frm_valid(frm_valid), .frm_bssid(frm_bssid), .frm_da(frm_da), .frm_hash(frm_hash),
    .acc_valid(acc_valid), .acc_ok(acc_ok), .mc_err(mc_err),
    .bss_id(bss_id), .assoc_id(assoc_id)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic model_acc(input logic [47:0] b, input logic [47:0] d, input logic [5:0] h);
    logic bss_ok, dst_ok;
    bss_ok = (((b ^ m_sta) & m_mask) == '0) || (b == m_bss);
    if (&d) dst_ok = 1'b1;
    else if (d[0]) dst_ok = m_mc[h];
    else dst_ok = ((d ^ m_sta) & m_mask) == '0;
    return bss_ok && dst_ok;
  endfunction

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    case (sel)
      3'd0: m_sta[31:0] = d;
      3'd1: m_sta[47:32] = d[15:0];
      3'd2: m_bss[31:0] = d;
      3'd3: m_bss[47:32] = d[15:0];
      3'd4: m_mask[31:0] = d;
      3'd5: m_mask[47:32] = d[15:0];
      3'd6: m_mc[31:0] = d;
      default: m_mc[63:32] = d;
    endcase
  endtask

  task automatic wr48(input logic [2:0] sel_lo, input logic [47:0] v);
    wr(sel_lo, v[31:0]);
    wr(sel_lo + 3'd1, {16'h0, v[47:32]});
  endtask

  task automatic mcop(input logic set, input logic [6:0] idx, input string tag);
    @(negedge clk);
    mc_op_valid = 1'b1; mc_op_set = set; mc_op_idx = idx;
    @(negedge clk);
    mc_op_valid = 1'b0;
    chk({63'h0, mc_err}, {63'h0, (idx >= 7'd64)}, tag);
    if (idx < 7'd64) m_mc[idx[5:0]] = set;
  endtask

  task automatic frame(input logic [47:0] b, input logic [47:0] d, input logic [5:0] h,
                       input logic exp_ok, input string tag);
    @(negedge clk);
    frm_valid = 1'b1; frm_bssid = b; frm_da = d; frm_hash = h;
    @(negedge clk);
    frm_valid = 1'b0;
    chk({62'h0, acc_valid, acc_ok}, {62'h0, 1'b1, exp_ok}, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R12: watchdog expired, got hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  localparam logic [47:0] BCAST = '1;

  initial begin
    logic [47:0] vb1, vb2, msk, old_sta;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk({acc_valid, acc_ok, mc_err}, 3'b000, "R1 outputs");
    chk(bss_id, 48'h0, "R1 bss_id");
    chk(assoc_id, 14'h0, "R1 assoc_id");
    frame(48'h0, 48'h0, 6'd0, 1'b1, "R1 zero station accept");
    frame(48'h1, 48'h0, 6'd0, 1'b0, "R1 full mask reject");
    frame(48'h0, 48'h01005E000001, 6'd9, 1'b0, "R1 empty hash table");

    // R5 word split
    wr48(3'd0, 48'hA1B2_C3D4_E5F6);
    wr48(3'd2, 48'h1122_3344_5566);
    chk(bss_id, 48'h1122_3344_5566, "R5 bssid words");
    frame(48'h1122_3344_5566, 48'hA1B2_C3D4_E5F6, 6'd0, 1'b1, "R5 station word split");
    frame(48'h1122_3344_5566, 48'hA1B3_C3D4_E5F6, 6'd0, 1'b0, "R5 high word bit");

    // R6 association ID field
    wr(3'd3, 32'hFFFF_FFFF);
    chk(assoc_id, 14'h3FFF, "R6 aid all ones");
    chk(bss_id[47:32], 16'hFFFF, "R6 bss hi all ones");
    wr(3'd3, 32'h1234_5678);
    chk(assoc_id, 14'h1234, "R6 aid field");
    chk(bss_id, 48'h5678_3344_5566, "R6 bss hi");

    // R3 single-bit flips under a full mask
    for (int i = 0; i < 48; i++)
      frame(m_sta ^ (48'h1 << i), BCAST, 6'd0, 1'b0, $sformatf("R3 flip bit %0d", i));
    frame(m_sta, BCAST, 6'd0, 1'b1, "R3 exact station");
    frame(m_bss, BCAST, 6'd0, 1'b1, "R10 joined bssid broadcast");

    // R11 unicast destination
    frame(m_bss, m_sta ^ 48'h0000_0100_0000, 6'd0, 1'b0, "R11 other unicast");
    frame(m_bss, m_sta, 6'd0, 1'b1, "R11 own unicast");

    // R4 four-bit example
    wr48(3'd0, 48'h1);
    wr48(3'd4, 48'h2);
    frame(48'h4, BCAST, 6'd0, 1'b1, "R4 bssid 0100");
    frame(48'h9, BCAST, 6'd0, 1'b1, "R4 bssid 1001");
    frame(48'hD, BCAST, 6'd0, 1'b1, "R4 bssid 1101");
    frame(48'h6, BCAST, 6'd0, 1'b0, "R4 bssid 0110");

    // R2 virtual BSS mask
    wr48(3'd0, 48'h0200_0000_0010);
    wr48(3'd2, 48'h5A5A_5A5A_5A5A);
    vb1 = 48'h0200_0000_0011;
    vb2 = 48'h0200_0000_0014;
    msk = ~(m_sta ^ vb1) & ~(m_sta ^ vb2);
    wr48(3'd4, msk);
    frame(vb1, BCAST, 6'd0, 1'b1, "R2 virtual bss 1");
    frame(vb2, BCAST, 6'd0, 1'b1, "R2 virtual bss 2");
    frame(48'h5A5A_5A5A_5A5A, BCAST, 6'd0, 1'b1, "R2 joined bssid");
    for (int v = 0; v < 256; v++)
      frame({m_sta[47:8], 8'(v)}, BCAST, 6'd0,
            model_acc({m_sta[47:8], 8'(v)}, BCAST, 6'd0), $sformatf("R2 sweep %0d", v));
    frame(m_sta ^ 48'h0100_0000_0000, BCAST, 6'd0, 1'b0, "R2 upper bit differs");

    // R7 / R9 every hash index
    wr48(3'd4, '1);
    for (int k = 0; k < 64; k++) begin
      mcop(1'b1, 7'(k), "R8 valid idx no error");
      frame(m_sta, 48'h3300_0000_0001, 6'(k), 1'b1, $sformatf("R9 hash %0d set", k));
      frame(m_sta, 48'h3300_0000_0001, 6'((k + 1) % 64), 1'b0, $sformatf("R9 hash %0d neighbour", k));
      mcop(1'b0, 7'(k), "R8 valid idx no error");
      frame(m_sta, 48'h3300_0000_0001, 6'(k), 1'b0, $sformatf("R7 hash %0d cleared", k));
    end
    wr(3'd7, 32'h0000_0020);
    frame(m_sta, 48'h3300_0000_0001, 6'd37, 1'b1, "R7 high word bit 5 is index 37");
    frame(m_sta, 48'h3300_0000_0001, 6'd5, 1'b0, "R7 low index 5 untouched");
    wr(3'd6, 32'h8000_0000);
    frame(m_sta, 48'h3300_0000_0001, 6'd31, 1'b1, "R7 low word bit 31");
    frame(m_sta, 48'h3300_0000_0001, 6'd63, 1'b0, "R7 index 63 clear");

    // R7 same-cycle word write and bit op
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 3'd6; reg_wdata = 32'h0000_0000;
    mc_op_valid = 1'b1; mc_op_set = 1'b1; mc_op_idx = 7'd3;
    @(negedge clk);
    reg_wr = 1'b0; mc_op_valid = 1'b0;
    m_mc[31:0] = 32'h0000_0008;
    frame(m_sta, 48'h3300_0000_0001, 6'd3, 1'b1, "R7 bit op wins");
    frame(m_sta, 48'h3300_0000_0001, 6'd31, 1'b0, "R7 word write applied");

    // R10 broadcast with empty table
    wr(3'd6, 32'h0); wr(3'd7, 32'h0);
    frame(m_sta, BCAST, 6'd12, 1'b1, "R10 broadcast empty table");

    // R8 out-of-range ops change nothing
    for (int j = 64; j < 128; j++)
      mcop(1'b1, 7'(j), $sformatf("R8 idx %0d error", j));
    for (int h = 0; h < 64; h += 7)
      frame(m_sta, 48'h3300_0000_0001, 6'(h), 1'b0, $sformatf("R8 table unchanged %0d", h));

    // R12 write in same cycle as frame
    old_sta = m_sta;
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 3'd0; reg_wdata = 32'hDEAD_BEEE;
    frm_valid = 1'b1; frm_bssid = old_sta; frm_da = old_sta; frm_hash = '0;
    @(negedge clk);
    reg_wr = 1'b0; frm_valid = 1'b0;
    chk({62'h0, acc_valid, acc_ok}, 64'h3, "R12 old address used");
    m_sta[31:0] = 32'hDEAD_BEEE;
    frame(old_sta, old_sta, 6'd0, 1'b0, "R12 new address next frame");
    @(negedge clk);
    chk({62'h0, acc_valid, acc_ok}, 64'h0, "R12 idle after frame");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule